// File: doc/BRIEF.md
# Level-synchronous graph traversal engine

The engine walks a graph held in its own on-chip tables and labels every vertex. In traversal-depth mode it performs breadth-first search from a chosen root, writing each vertex's hop distance from that root. In component mode it runs the same walk, but each vertex gets the number of the connected piece it belongs to. Whenever one piece is exhausted, a restart scan looks for the lowest-numbered vertex still unlabelled, announces it with a one-cycle pulse, and seeds the next piece from it with the next identifier.

Before a run, the graph is loaded through two write ports. The neighbour table holds one neighbour vertex number per entry. The index table, addressed by vertex number, holds the first neighbour-table address of that vertex's list and the length of the list. A start pulse captures the mode and the root and marks every label unvisited. The engine then sweeps the vertex range once per level. Each vertex on the current level of the current piece has its list walked. The walk never touches a visited vertex, so every label it writes is the minimum of the old value and the current level plus one. When all labels are settled, `done` rises. The labels are read through a combinational read port.

Top module: `graph_walker`

## Requirements
- R1: After reset, `busy`, `done` and `seed_valid` are 0.
- R2: A start pulse accepted while idle or done sets every label to the unvisited code (all ones, 2^(VW+1)-1) and the root's label to 0. The root's label stays 0 for the whole run.
- R3: In traversal-depth mode (`cc_mode`=0), each vertex reachable from the root along directed edges ends with its minimum hop count from the root.
- R4: In traversal-depth mode, a vertex not reachable from the root keeps the unvisited code.
- R5: A vertex whose label is not the unvisited code is never rewritten before the next start, whatever edges lead to it.
- R6: `done` rises once a full level sweep labels no new vertex (in traversal-depth mode) and stays high until the next accepted start. A start pulse while `busy` is 1 is ignored.
- R7: In component mode (`cc_mode`=1), the root's piece gets identifier 0. Each later piece gets the previous identifier plus one, and its seed is the lowest-numbered vertex still unvisited when the previous piece finished.
- R8: `seed_valid` is a one-cycle pulse, raised only in component mode, with `seed_vertex` carrying the vertex that seeds the new piece.
- R9: In component mode, `done` rises only when the restart scan finds no unvisited vertex. Every label is then below the unvisited code.
- R10: `lbl_data` shows, in the same cycle, the label of vertex `lbl_addr`: the hop count if the run was started in traversal-depth mode, or the piece identifier if it was started in component mode.
- R11: The neighbour list of vertex v is found at index entry v: `cnt` entries from address `base`, wrapping modulo the table size. A count of 0 means v has no neighbours. Lists may sit anywhere in the neighbour table, in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index table write enable |
| idx_addr | input | VW | Vertex whose index entry is written |
| idx_base | input | EW | First neighbour-table address of the list |
| idx_cnt | input | VW+1 | Number of neighbours in the list |
| adj_we | input | 1 | Neighbour table write enable |
| adj_addr | input | EW | Neighbour table address |
| adj_vertex | input | VW | Neighbour vertex number stored |
| start | input | 1 | Starts a run (taken while idle or done) |
| cc_mode | input | 1 | 0: hop distances, 1: connected pieces |
| root | input | VW | First vertex of the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Labels final |
| seed_valid | output | 1 | One-cycle pulse: a new piece starts |
| seed_vertex | output | VW | Seed of the new piece |
| lbl_addr | input | VW | Vertex whose label is read |
| lbl_data | output | VW+1 | Label of `lbl_addr` |

## Verification
The root's zero label is visible one cycle after the start pulse, before any list has been walked. The bench reads it at the first falling edge after the start is taken. Seed pulses last one cycle, so the bench polls `seed_valid` at every falling edge of a run and compares each pulse, in order, with the seed sequence of its software component model. Final labels are read only after `done` is seen, by setting `lbl_addr` at a falling edge and sampling shortly after, since the read path has no register. `done` is sampled again a few cycles later to confirm it holds.

// File: rtl/graph_walker.sv
module graph_walker #(
  parameter int VW = 6,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic [VW-1:0] idx_addr,
  input  logic [EW-1:0] idx_base,
  input  logic [VW:0]   idx_cnt,
  input  logic          adj_we,
  input  logic [EW-1:0] adj_addr,
  input  logic [VW-1:0] adj_vertex,
  input  logic          start,
  input  logic          cc_mode,
  input  logic [VW-1:0] root,
  output logic          busy,
  output logic          done,
  output logic          seed_valid,
  output logic [VW-1:0] seed_vertex,
  input  logic [VW-1:0] lbl_addr,
  output logic [VW:0]   lbl_data
);
  localparam int NV = 1 << VW;
  localparam int NE = 1 << EW;
  localparam int LW = VW + 1;
  localparam logic [LW-1:0] UNVIS = '1;
  localparam logic [VW-1:0] LASTV = VW'(NV - 1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_EDGE, S_LVL, S_SEEK, S_DONE} st_t;

  logic [EW-1:0] base_m [NV];
  logic [LW-1:0] cnt_m  [NV];
  logic [VW-1:0] adj_m  [NE];
  logic [LW-1:0] lvl_q  [NV];
  logic [LW-1:0] cid_q  [NV];

  st_t           st;
  logic          mode_q;
  logic [VW-1:0] root_q;
  logic [VW-1:0] cur;
  logic [EW-1:0] ep;
  logic [LW-1:0] rem;
  logic [LW-1:0] lvl;
  logic [LW-1:0] cid;
  logic          newf;

  logic [VW-1:0] nb;
  logic          frontier;
  logic          last_v;
  logic          accept;

  assign nb       = adj_m[ep];
  assign frontier = (lvl_q[cur] == lvl) && (cid_q[cur] == cid);
  assign last_v   = (cur == LASTV);
  assign accept   = start && ((st == S_IDLE) || (st == S_DONE));
  assign busy     = (st != S_IDLE) && (st != S_DONE);
  assign done     = (st == S_DONE);
  assign lbl_data = mode_q ? cid_q[lbl_addr] : lvl_q[lbl_addr];

  always_ff @(posedge clk) begin
    if (idx_we) begin
      base_m[idx_addr] <= idx_base;
      cnt_m[idx_addr]  <= idx_cnt;
    end
    if (adj_we) adj_m[adj_addr] <= adj_vertex;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      mode_q      <= 1'b0;
      root_q      <= '0;
      cur         <= '0;
      ep          <= '0;
      rem         <= '0;
      lvl         <= '0;
      cid         <= '0;
      newf        <= 1'b0;
      seed_valid  <= 1'b0;
      seed_vertex <= '0;
      for (int i = 0; i < NV; i++) begin
        lvl_q[i] <= UNVIS;
        cid_q[i] <= UNVIS;
      end
    end else begin
      seed_valid <= 1'b0;
      if (accept) begin
        for (int i = 0; i < NV; i++) begin
          lvl_q[i] <= UNVIS;
          cid_q[i] <= UNVIS;
        end
        lvl_q[root] <= '0;
        cid_q[root] <= '0;
        mode_q      <= cc_mode;
        root_q      <= root;
        lvl         <= '0;
        cid         <= '0;
        newf        <= 1'b0;
        cur         <= '0;
        st          <= S_SCAN;
      end else begin
        case (st)
          S_SCAN: begin
            if (frontier) begin
              ep  <= base_m[cur];
              rem <= cnt_m[cur];
              st  <= S_EDGE;
            end else if (last_v) begin
              st <= S_LVL;
            end else begin
              cur <= cur + 1'b1;
            end
          end
          S_EDGE: begin
            if (rem == '0) begin
              if (last_v) st <= S_LVL;
              else begin
                cur <= cur + 1'b1;
                st  <= S_SCAN;
              end
            end else begin
              if (lvl_q[nb] == UNVIS) begin
                lvl_q[nb] <= lvl + 1'b1;
                cid_q[nb] <= cid;
                newf      <= 1'b1;
              end
              ep  <= ep + 1'b1;
              rem <= rem - 1'b1;
            end
          end
          S_LVL: begin
            cur <= '0;
            if (newf) begin
              lvl  <= lvl + 1'b1;
              newf <= 1'b0;
              st   <= S_SCAN;
            end else if (mode_q) begin
              st <= S_SEEK;
            end else begin
              st <= S_DONE;
            end
          end
          S_SEEK: begin
            if (lvl_q[cur] == UNVIS) begin
              lvl_q[cur]  <= '0;
              cid_q[cur]  <= cid + 1'b1;
              cid         <= cid + 1'b1;
              lvl         <= '0;
              seed_valid  <= 1'b1;
              seed_vertex <= cur;
              cur         <= '0;
              st          <= S_SCAN;
            end else if (last_v) begin
              st <= S_DONE;
            end else begin
              cur <= cur + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/graph_walker_chk.sv
module graph_walker_chk #(
  parameter int VW = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        seed_valid,
  input logic        mode_q,
  input logic [VW:0] lvl0,
  input logic [VW:0] root_lbl
);
  localparam logic [VW:0] UNVIS = '1;

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q));

  p_seed_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid |=> !seed_valid);

  p_seed_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid |-> (mode_q && busy));

  p_keep_label_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl0 != UNVIS && !start) |=> (lvl0 == $past(lvl0)));

  p_root_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (root_lbl == '0));

  p_done_noseed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !seed_valid);
endmodule

bind graph_walker graph_walker_chk #(.VW(VW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .start(start),
  .busy(busy),
  .done(done),
  .seed_valid(seed_valid),
  .mode_q(mode_q),
  .lvl0(lvl_q[0]),
  .root_lbl(lvl_q[root_q])
);

// File: tb/graph_walker_tb.sv
`timescale 1ns/1ps
module graph_walker_tb;
  localparam int VW = 4;
  localparam int EW = 6;
  localparam int NV = 16;
  localparam int NE = 64;
  localparam int UNV = 31;

  logic clk = 0;
  logic rst_n = 0;
  logic idx_we = 0, adj_we = 0, start = 0, cc_mode = 0;
  logic [VW-1:0] idx_addr = '0, adj_vertex = '0, root = '0, lbl_addr = '0;
  logic [EW-1:0] idx_base = '0, adj_addr = '0;
  logic [VW:0] idx_cnt = '0;
  logic busy, done, seed_valid;
  logic [VW-1:0] seed_vertex;
  logic [VW:0] lbl_data;

  int checks = 0, failures = 0, cycles = 0;
  int m_base[NV], m_cnt[NV], m_adj[NE], exp_lbl[NV], exp_seed[NV], n_seed;

  always #4 clk = ~clk;

  graph_walker #(.VW(VW), .EW(EW)) u_dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic load_graph(int g);
    for (int v = 0; v < NV; v++) begin
      m_cnt[v]  = (v * 3 + g * 5) % 4;
      if (g == 3 && v >= 8) m_cnt[v] = 0;
      m_base[v] = (g % 2) ? (15 - v) * 4 : v * 4;
      for (int k = 0; k < 4; k++)
        m_adj[(m_base[v] + k) % NE] = (v * 5 + k * 7 + g * 3 + 1) % NV;
    end
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      idx_we = 1; idx_addr = VW'(v); idx_base = EW'(m_base[v]); idx_cnt = (VW+1)'(m_cnt[v]);
    end
    for (int a = 0; a < NE; a++) begin
      @(negedge clk);
      idx_we = 0; adj_we = 1; adj_addr = EW'(a); adj_vertex = VW'(m_adj[a]);
    end
    @(negedge clk);
    idx_we = 0; adj_we = 0;
  endtask

  task automatic model(int r, bit cc);
    int lv[NV], cm[NV];
    int lev, cid, nb, u;
    bit newf, fin;
    for (int v = 0; v < NV; v++) begin lv[v] = UNV; cm[v] = UNV; end
    lv[r] = 0; cm[r] = 0; lev = 0; cid = 0; n_seed = 0; fin = 0;
    while (!fin) begin
      newf = 0;
      for (int v = 0; v < NV; v++)
        if (lv[v] == lev && cm[v] == cid)
          for (int k = 0; k < m_cnt[v]; k++) begin
            nb = m_adj[(m_base[v] + k) % NE];
            if (lv[nb] == UNV) begin lv[nb] = lev + 1; cm[nb] = cid; newf = 1; end
          end
      if (newf) lev++;
      else if (cc) begin
        u = -1;
        for (int v = NV - 1; v >= 0; v--) if (lv[v] == UNV) u = v;
        if (u < 0) fin = 1;
        else begin
          cid++; lv[u] = 0; cm[u] = cid; lev = 0;
          exp_seed[n_seed] = u; n_seed++;
        end
      end else fin = 1;
    end
    for (int v = 0; v < NV; v++) exp_lbl[v] = cc ? cm[v] : lv[v];
  endtask

  task automatic run(int g, int r, bit cc, bit inject);
    int seen = 0, n = 0;
    model(r, cc);
    @(negedge clk);
    start = 1; root = VW'(r); cc_mode = cc;
    @(negedge clk);
    start = 0;
    lbl_addr = VW'(r);
    #1 chk("R2", int'(lbl_data), 0);
    while (!done && n < 20000) begin
      if (inject && n == 4) begin start = 1; root = VW'((r + 5) % NV); cc_mode = !cc; end
      else start = 0;
      if (seed_valid) begin
        if (seen < n_seed) chk("R7", int'(seed_vertex), exp_seed[seen]);
        else chk("R8", 1, 0);
        seen++;
      end
      @(negedge clk);
      n++;
    end
    start = 0;
    chk("R6", int'(done), 1);
    chk("R8", seen, n_seed);
    for (int v = 0; v < NV; v++) begin
      lbl_addr = VW'(v);
      #1;
      if (cc) begin
        chk("R7", int'(lbl_data), exp_lbl[v]);
        chk("R9", int'(lbl_data) < UNV, 1);
      end else if (exp_lbl[v] == UNV) chk("R4", int'(lbl_data), UNV);
      else if (g % 2) chk("R11", int'(lbl_data), exp_lbl[v]);
      else if (exp_lbl[v] >= 2) chk("R5", int'(lbl_data), exp_lbl[v]);
      else chk("R3", int'(lbl_data), exp_lbl[v]);
      chk("R10", int'(lbl_data), exp_lbl[v]);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R6", int'(done), 1);
    chk("R1", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", int'(busy), 0);
    chk("R1", int'(done), 0);
    chk("R1", int'(seed_valid), 0);
    @(negedge clk);
    rst_n = 1;
    for (int g = 0; g < 4; g++) begin
      load_graph(g);
      for (int r = 0; r < NV; r += 3) run(g, r, 1'b0, r == 3);
      run(g, 0, 1'b1, 1'b0);
      run(g, 7, 1'b1, g == 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule